// File: doc/BRIEF.md
# Four-Lane Byte/Word Data FIFO

This block is a data queue whose storage is split into four byte-wide lanes of sixteen entries each. A 32-bit word access moves four consecutive stream bytes at once, one per lane, so the queue holds up to 64 bytes. A byte access moves a single byte. Byte writes are accepted only while fewer than 16 bytes are held, so the byte port has an effective depth of one lane. Bytes are kept in stream order and the lanes are visited in rotation. Word accesses therefore work at any lane alignment, and bytes and words may be mixed freely.

The same module serves both directions of a serial link, selected by a parameter. In the transmit variant the host pushes words or bytes and the shift engine pops bytes. In the receive variant the engine pushes bytes and the host pops words or bytes. Each variant exposes a status vector of sticky flags at its own fixed bit positions: full, half-full, empty or data-available, and a fill-level trigger. Writing 1 to a bit of the clear input clears that flag. A refused access sets an illegal-access flag, and that flag drives the level-high interrupt.

Top module: `quad_lane_fifo`

## Requirements
- R1: Asynchronous reset and the synchronous `soft_rst` input both empty the queue, zero the whole status vector and drop `irq`.
- R2: A word write stores `wdata[7:0]` as the earliest stream byte and `wdata[31:24]` as the latest. A word read returns the oldest byte in `rdata[7:0]` and the next three bytes above it. A byte read takes the oldest byte from `rdata[7:0]`. Order is preserved at any lane alignment.
- R3: Through words the queue holds 64 bytes. A word write with fewer than 4 free bytes, and a word read with fewer than 4 bytes held, are refused without moving any pointer, and they set the illegal flag (bit 12).
- R4: A byte write while 16 or more bytes are held is refused and sets bit 12. The refused byte is not stored.
- R5: A byte read while the queue is empty is refused and sets bit 12.
- R6: Transmit variant (`RX_SIDE`=0) flag positions: bit 3 full (64 bytes), bit 2 half-full (at least 32), bit 1 empty, bit 0 trigger (occupancy at most `TRIG_LEVEL`).
- R7: Receive variant flag positions: bit 8 full, bit 7 half-full, bit 6 a whole word available (at least 4), bit 5 trigger (occupancy at least `TRIG_LEVEL`), bit 11 at least one byte available. All other bits except 12 read 0.
- R8: Flags are sticky. A 1 in `clr` clears a bit at the next edge unless its condition still holds. A condition is sampled one cycle after the occupancy change that causes it.
- R9: `irq` is high exactly while the illegal flag (bit 12) is set.
- R10: A word and a byte access on the same side in the same cycle are both refused and set bit 12.
- R11: A write and a read in the same cycle are both performed. Each is judged on the occupancy at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of queue and flags |
| wr_word | input | 1 | Push four bytes from `wdata` |
| wr_byte | input | 1 | Push one byte from `wdata[7:0]` |
| wdata | input | 32 | Write data, little-endian |
| rd_word | input | 1 | Pop four bytes |
| rd_byte | input | 1 | Pop one byte |
| rdata | output | 32 | Oldest four bytes, oldest in bits 7:0 (show-ahead) |
| clr | input | 13 | Write-one-to-clear mask for the status vector |
| status | output | 13 | Sticky status flags |
| irq | output | 1 | Level-high illegal-access interrupt |

## Verification
The push side and the pop side can act in the same clock cycle. The bench provokes this with a word write alongside a word read on a partly filled queue. It checks that the read returns the older word and that the newer word follows. It also issues a write together with a byte read on an empty queue. There the read must be refused, because legality is judged on the occupancy at the start of the cycle, while the write still lands. The word that was written is then read back and compared.

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo #(
  parameter int LANES      = 4,
  parameter int LANE_DEPTH = 16,
  parameter int RX_SIDE    = 0,
  parameter int TRIG_LEVEL = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 wr_word,
  input  logic                 wr_byte,
  input  logic [8*LANES-1:0]   wdata,
  input  logic                 rd_word,
  input  logic                 rd_byte,
  output logic [8*LANES-1:0]   rdata,
  input  logic [12:0]          clr,
  output logic [12:0]          status,
  output logic                 irq
);
  localparam int CAP = LANES * LANE_DEPTH;
  localparam int LW  = $clog2(LANES);
  localparam int PW  = $clog2(CAP);
  localparam int RW  = PW - LW;
  localparam int CW  = PW + 1;

  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, push, pop;
  logic [LANES-1:0][7:0] lane_rd;
  logic [12:0] cond;

  wire w_ok  = wr_word & ~wr_byte & (cnt <= CW'(CAP - LANES));
  wire b_ok  = wr_byte & ~wr_word & (cnt <  CW'(LANE_DEPTH));
  wire rw_ok = rd_word & ~rd_byte & (cnt >= CW'(LANES));
  wire rb_ok = rd_byte & ~rd_word & (cnt != '0);
  wire bad   = ((wr_word | wr_byte) & ~(w_ok | b_ok)) |
               ((rd_word | rd_byte) & ~(rw_ok | rb_ok));

  assign push = w_ok  ? CW'(LANES) : CW'(b_ok);
  assign pop  = rw_ok ? CW'(LANES) : CW'(rb_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (soft_rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + PW'(push);
      rp  <= rp + PW'(pop);
      cnt <= cnt + push - pop;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [LANE_DEPTH];
    logic [LW-1:0] woff;
    logic [RW-1:0] wrow, rrow;
    assign woff = LW'(l) - wp[LW-1:0];
    assign wrow = wp[PW-1:LW] + RW'(LW'(l) < wp[LW-1:0]);
    assign rrow = rp[PW-1:LW] + RW'(LW'(l) < rp[LW-1:0]);
    wire       we  = ~soft_rst & (w_ok | (b_ok & (wp[LW-1:0] == LW'(l))));
    wire [7:0] din = w_ok ? wdata[{woff, 3'b000} +: 8] : wdata[7:0];
    always_ff @(posedge clk) begin
      if (we) mem[wrow] <= din;
    end
    assign lane_rd[l] = mem[rrow];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    wire [LW-1:0] sel = rp[LW-1:0] + LW'(i);
    assign rdata[8*i +: 8] = lane_rd[sel];
  end

  wire full  = (cnt == CW'(CAP));
  wire half  = (cnt >= CW'(CAP / 2));
  wire empty = (cnt == '0);
  wire wav   = (cnt >= CW'(LANES));

  if (RX_SIDE != 0) begin : g_rx
    assign cond = {bad, ~empty, 2'b00, full, half, wav, (cnt >= CW'(TRIG_LEVEL)), 5'b00000};
  end else begin : g_tx
    assign cond = {bad, 8'h00, full, half, empty, (cnt <= CW'(TRIG_LEVEL))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= '0;
    else if (soft_rst) status <= '0;
    else               status <= (status & ~clr) | cond;
  end

  assign irq = status[12];
endmodule

// File: rtl/quad_lane_fifo_chk.sv
module quad_lane_fifo_chk #(
  parameter int LANES      = 4,
  parameter int LANE_DEPTH = 16
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   soft_rst,
  input logic                                   wr_word,
  input logic                                   wr_byte,
  input logic                                   rd_word,
  input logic                                   rd_byte,
  input logic [$clog2(LANES*LANE_DEPTH):0]      cnt,
  input logic                                   full_flag,
  input logic                                   irq
);
  localparam int CAP = LANES * LANE_DEPTH;
  localparam int CW  = $clog2(CAP) + 1;

  wire quiet_rd = !rd_word && !rd_byte && !soft_rst;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CAP));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !wr_byte && quiet_rd && cnt > CW'(CAP - LANES)) |=> ($stable(cnt) && irq));

  p_byte_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && !wr_word && quiet_rd && cnt >= CW'(LANE_DEPTH)) |=> ($stable(cnt) && irq));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_byte && !rd_word && !soft_rst && cnt == '0) |=> irq);

  p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt == '0 && !irq && !full_flag));

  p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(CAP) && !soft_rst) |=> full_flag);

  p_port_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && wr_byte && !soft_rst) |=> irq);
endmodule

bind quad_lane_fifo quad_lane_fifo_chk #(.LANES(LANES), .LANE_DEPTH(LANE_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .wr_word(wr_word), .wr_byte(wr_byte), .rd_word(rd_word), .rd_byte(rd_byte),
  .cnt(cnt), .full_flag(status[(RX_SIDE != 0) ? 8 : 3]), .irq(irq)
);

// File: tb/test_quad_lane_fifo.sv
module test_quad_lane_fifo;
  localparam int CLK_P = 10;
  localparam int NV    = 12;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'b1000, 32'h44332211, 32'h0},
    {1'b0, 4'b1000, 32'h88776655, 32'h0},
    {1'b0, 4'b0100, 32'h00000099, 32'h0},
    {1'b1, 4'b0001, 32'h0, 32'h00000011},
    {1'b1, 4'b0010, 32'h0, 32'h55443322},
    {1'b1, 4'b0001, 32'h0, 32'h00000066},
    {1'b0, 4'b0010, 32'h0, 32'h0},
    {1'b1, 4'b0001, 32'h0, 32'h00000077},
    {1'b1, 4'b0001, 32'h0, 32'h00000088},
    {1'b1, 4'b0001, 32'h0, 32'h00000099},
    {1'b0, 4'b1000, 32'hDDCCBBAA, 32'h0},
    {1'b1, 4'b0010, 32'h0, 32'hDDCCBBAA}
  };

  logic clk = 0, rst_n = 0;
  logic t_srst = 0, t_ww = 0, t_bw = 0, t_rw = 0, t_rb = 0;
  logic [31:0] t_wd = '0, t_rd;
  logic [12:0] t_clr = '0, t_st;
  logic t_irq;
  logic r_srst = 0, r_ww = 0, r_bw = 0, r_rw = 0, r_rb = 0;
  logic [31:0] r_wd = '0, r_rd;
  logic [12:0] r_clr = '0, r_st;
  logic r_irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  quad_lane_fifo #(.RX_SIDE(0)) i_quad_lane_fifo (
    .clk(clk), .rst_n(rst_n), .soft_rst(t_srst), .wr_word(t_ww), .wr_byte(t_bw),
    .wdata(t_wd), .rd_word(t_rw), .rd_byte(t_rb), .rdata(t_rd), .clr(t_clr),
    .status(t_st), .irq(t_irq));

  quad_lane_fifo #(.RX_SIDE(1)) i_quad_lane_fifo_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(r_srst), .wr_word(r_ww), .wr_byte(r_bw),
    .wdata(r_wd), .rd_word(r_rw), .rd_byte(r_rb), .rdata(r_rd), .clr(r_clr),
    .status(r_st), .irq(r_irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tx_cyc(input logic ww, input logic bw, input logic rw, input logic rb,
                        input logic [31:0] wd, input logic chk, input logic [31:0] exp,
                        input string tag);
    t_ww = ww; t_bw = bw; t_rw = rw; t_rb = rb; t_wd = wd;
    #1;
    if (chk) check(rb ? {24'h0, t_rd[7:0]} : t_rd, exp, tag);
    @(posedge clk); @(negedge clk);
    t_ww = 0; t_bw = 0; t_rw = 0; t_rb = 0;
  endtask

  task automatic tx_clear();
    t_clr = '1; idle(); t_clr = '0;
  endtask

  task automatic tx_soft();
    t_srst = 1; idle(); t_srst = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check({19'h0, t_st}, 32'h0, "R1 tx status after reset");
    check({31'h0, t_irq}, 32'h0, "R1 irq after reset");
    check({19'h0, r_st}, 32'h0, "R1 rx status after reset");
    idle();
    check({19'h0, t_st}, 32'h003, "R6 tx empty+trigger when idle");
    check({19'h0, r_st}, 32'h000, "R7 rx idle flags");

    for (int k = 0; k < NV; k++)
      tx_cyc(VEC[k][67], VEC[k][66], VEC[k][65], VEC[k][64], VEC[k][63:32],
             VEC[k][68], VEC[k][31:0], "R2 stream data");
    check({31'h0, t_irq}, 32'h1, "R3 short word read flagged");
    check({31'h0, t_irq}, {31'h0, t_st[12]}, "R9 irq follows bit 12");

    tx_clear();
    check({19'h0, t_st}, 32'h003, "R8 clear leaves live conditions");
    check({31'h0, t_irq}, 32'h0, "R9 irq dropped after clear");

    for (int k = 0; k < 16; k++) tx_cyc(1, 0, 0, 0, 32'hA5000000 | k, 0, 0, "");
    idle();
    check({31'h0, t_st[3]}, 32'h1, "R6 full at 64 bytes");
    check({31'h0, t_st[2]}, 32'h1, "R6 half-full");
    tx_cyc(1, 0, 0, 0, 32'hDEADBEEF, 0, 0, "");
    check({31'h0, t_irq}, 32'h1, "R3 overflow word flagged");
    for (int k = 0; k < 16; k++) tx_cyc(0, 0, 1, 0, 0, 1, 32'hA5000000 | k, "R3 drain after refused write");

    tx_soft();
    check({19'h0, t_st}, 32'h0, "R1 soft reset clears flags");
    check({31'h0, t_irq}, 32'h0, "R1 soft reset drops irq");

    for (int k = 0; k < 16; k++) tx_cyc(0, 1, 0, 0, 32'h10 + k, 0, 0, "");
    check({31'h0, t_irq}, 32'h0, "R4 sixteen bytes accepted");
    tx_cyc(0, 1, 0, 0, 32'hEE, 0, 0, "");
    check({31'h0, t_irq}, 32'h1, "R4 seventeenth byte refused");
    tx_cyc(1, 0, 0, 0, 32'hCAFEF00D, 0, 0, "");
    for (int k = 0; k < 16; k++) tx_cyc(0, 0, 0, 1, 0, 1, 32'h10 + k, "R4 byte order");
    tx_cyc(0, 0, 1, 0, 0, 1, 32'hCAFEF00D, "R4 refused byte not stored");

    tx_clear();
    check({31'h0, t_irq}, 32'h0, "R5 irq clear before test");
    tx_cyc(0, 0, 0, 1, 0, 0, 0, "");
    check({31'h0, t_irq}, 32'h1, "R5 byte read on empty");

    tx_clear();
    tx_cyc(1, 1, 0, 0, 32'h12345678, 0, 0, "");
    check({31'h0, t_irq}, 32'h1, "R10 word+byte clash flagged");
    tx_clear();
    check({19'h0, t_st}, 32'h003, "R10 clash stored nothing");

    tx_cyc(1, 0, 0, 0, 32'h01020304, 0, 0, "");
    tx_cyc(1, 0, 1, 0, 32'h05060708, 1, 32'h01020304, "R11 read beside write");
    tx_cyc(0, 0, 1, 0, 0, 1, 32'h05060708, "R11 write beside read kept");
    tx_clear();
    tx_cyc(1, 0, 0, 1, 32'h0A0B0C0D, 0, 0, "");
    check({31'h0, t_irq}, 32'h1, "R11 read judged on start occupancy");
    tx_cyc(0, 0, 1, 0, 0, 1, 32'h0A0B0C0D, "R11 write kept while read refused");

    for (int k = 0; k < 8; k++) begin
      r_ww = 1; r_wd = 32'h11111111 * k; idle();
    end
    r_ww = 0; idle();
    check({19'h0, r_st}, 32'h08E0, "R7 rx flags at half");
    for (int k = 0; k < 8; k++) begin
      r_ww = 1; r_wd = 32'h0; idle();
    end
    r_ww = 0; idle();
    check({19'h0, r_st}, 32'h09E0, "R7 rx flags at full");
    check({31'h0, r_irq}, 32'h0, "R9 rx no illegal access");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule